// File: doc/BRIEF.md
# Symmetric Two-Channel PWM Generator with Buffered Duty Registers

This block produces two center-aligned pulse-width-modulated outputs from a shared triangular time base. A counter climbs from zero to a programmable top value, descends back to zero, and repeats without stopping. One full carrier cycle therefore lasts twice the top value in clocks. Each output follows its own 8-bit action table. The table maps four counter events to one of four actions on the output: nothing, drive low, drive high, or invert. The four events are reaching zero, reaching the top value, matching the compare value while climbing, and matching it while descending.

Duty values are written through a buffer register per channel. In the default mode a written value waits in the buffer and moves to the active compare register only when the counter is at zero. Both compare matches inside one carrier cycle therefore see the same value. A step from one duty to another moves straight from the old pulse width to the new one, with no in-between pulse. A per-channel mode bit can bypass the buffer so that a write takes effect on the next clock. The counter value and the zero and top event flags are brought out so that neighbouring logic can align to the carrier.

Top module: `pwm_center_gen`

## Requirements
- R1: After reset the counter steps by one every clock: up from 0 to `period`, then down to 0, then up again. A full cycle lasts 2×`period` clocks. With `period` = 0 the counter holds at 0.
- R2: `evt_zero` is high exactly while the count is 0, and `evt_period` is high exactly while the count equals `period`. Each is high for one clock per carrier cycle.
- R3: With the channel's `cmp_imm` bit at 0, a value written to a compare port is held in a buffer. The buffer is copied into the active compare register only on the clock where the count is 0. A carrier cycle that was already running when the write arrived completes with the old value.
- R4: When several writes reach one channel's buffer within a carrier cycle, the last one is the value applied at the next zero.
- R5: With the channel's `cmp_imm` bit at 1 (bit 0 for A, bit 1 for B), a write replaces the active compare value at once. It is used from the next count onward.
- R6: Each 8-bit action table is split into four 2-bit fields. Bits [1:0] act at zero, bits [3:2] at `period`, bits [5:4] on a compare match while counting up, and bits [7:6] on a compare match while counting down. The field codes are 0 = no change, 1 = drive low, 2 = drive high, 3 = invert. An output changes on the clock edge that ends the counter state holding the event.
- R7: A zero or `period` event takes priority over a compare match in the same state. A compare value of 0, or one equal to or above `period`, therefore never produces a compare action.
- R8: With table value 0x61 (low at zero, high on the up match, low on the down match, no change at `period`) and 0 < C < `period`, the output is high for 2×(`period`−C) clocks of each carrier cycle.
- R9: Reset sets the count to 0 and counting up, drives both outputs low, and clears both the buffer and the active compare registers of both channels.
- R10: The two channels share the time base but have separate compare values, modes and tables. Writing or configuring one channel does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period | input | 16 | Top value of the triangular count |
| cmp_a_wdata | input | 16 | Compare value for channel A |
| cmp_a_we | input | 1 | Write strobe for channel A compare |
| cmp_b_wdata | input | 16 | Compare value for channel B |
| cmp_b_we | input | 1 | Write strobe for channel B compare |
| cmp_imm | input | 2 | Per-channel bypass of the buffer (bit 0 = A, bit 1 = B) |
| act_a | input | 8 | Action table for channel A |
| act_b | input | 8 | Action table for channel B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| tb_count | output | 16 | Current counter value |
| evt_zero | output | 1 | Count equals zero |
| evt_period | output | 1 | Count equals `period` |

## Verification
Some behaviour is checked on every clock. The counter must step by exactly one and turn upward at zero. The active compare register must stay unchanged except at zero or on a bypass write. The top-value event must leave an output untouched when its action is "no change". A zero event with a "drive low" action must clear the output. Other behaviour shows only across whole carrier cycles, so only the bench's scenarios can reveal it. These are the high-time per cycle for each duty value, and the old width being kept for the cycle in which a buffered write lands. They also include last-write-wins within a cycle, the bypass mode changing the running cycle, and the alternating output of an invert action.

// File: rtl/pwm_center_pkg.sv
// Package: shared action encoding for the symmetric PWM generator.
// Assumes: 2-bit action fields, four fields per channel table.
package pwm_center_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_INV  = 2'd3
    } pwm_act_e;

    localparam int unsigned ACT_W   = 2;
    localparam int unsigned TABLE_W = 4 * ACT_W;

    // Next output level for a given action and current level.
    function automatic logic act_apply(input pwm_act_e a, input logic cur);
        case (a)
            ACT_LOW:  act_apply = 1'b0;
            ACT_HIGH: act_apply = 1'b1;
            ACT_INV:  act_apply = ~cur;
            default:  act_apply = cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tb_counter.sv
// Module: triangular up/down time-base counter.
// Counts 0..period then back to 0, forever; a top value of 0 parks the count.
// Assumes: period may change at any time; a count above a new top turns down.
module pwm_tb_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             at_zero,
    output logic             at_top
);

    // Advance the count and flip direction at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (period == '0) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (dir_up) begin
            if (cnt >= period) begin
                cnt    <= cnt - 1'b1;
                dir_up <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                cnt    <= cnt + 1'b1;
                dir_up <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Event decode from the present count.
    always_comb begin
        at_zero = (cnt == '0);
        at_top  = (cnt == period);
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |=> (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R1
    zero_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && period != '0) |=> (cnt == CNT_W'(1)));

endmodule

// File: rtl/pwm_cmp_shadow.sv
// Module: one compare channel with a buffer register and an active register.
// Buffered mode copies the buffer at the zero event; bypass mode writes through.
// Assumes: load_evt is high for one clock per carrier cycle.
module pwm_cmp_shadow #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             imm,
    input  logic             load_evt,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] buf_q;

    // Capture every write into the buffer; the last one wins.
    always_ff @(posedge clk) begin
        if (!rst_n)  buf_q <= '0;
        else if (we) buf_q <= wdata;
    end

    // Update the active value on a bypass write or at the zero event.
    always_ff @(posedge clk) begin
        if (!rst_n)              active <= '0;
        else if (we && imm)      active <= wdata;
        else if (load_evt)       active <= buf_q;
    end

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && !(we && imm)) |=> $stable(active));

endmodule

// File: rtl/pwm_action_out.sv
// Module: action-table driven output flop for one channel.
// Event priority: zero, then top, then the compare match in the current direction.
// Assumes: table fields [1:0] zero, [3:2] top, [5:4] up match, [7:6] down match.
module pwm_action_out
    import pwm_center_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]   cmp,
    input  logic               dir_up,
    input  logic               at_zero,
    input  logic               at_top,
    input  logic [TABLE_W-1:0] table_i,
    output logic               pwm
);

    pwm_act_e act_sel;

    // Pick the single action that applies in this counter state.
    always_comb begin
        if (at_zero)           act_sel = pwm_act_e'(table_i[1:0]);
        else if (at_top)       act_sel = pwm_act_e'(table_i[3:2]);
        else if (cnt == cmp)   act_sel = dir_up ? pwm_act_e'(table_i[5:4])
                                                : pwm_act_e'(table_i[7:6]);
        else                   act_sel = ACT_KEEP;
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm <= 1'b0;
        else        pwm <= act_apply(act_sel, pwm);
    end

    // R6
    top_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && !at_zero && table_i[3:2] == 2'd0) |=> $stable(pwm));

    // R7
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && table_i[1:0] == 2'd1) |=> !pwm);

endmodule

// File: rtl/pwm_center_gen.sv
// Module: two-channel center-aligned PWM generator (top).
// One shared triangular time base; per channel a buffered compare and an action table.
// Assumes: synchronous active-low reset; all inputs in the clk domain.
module pwm_center_gen
    import pwm_center_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   period,
    input  logic [CNT_W-1:0]   cmp_a_wdata,
    input  logic               cmp_a_we,
    input  logic [CNT_W-1:0]   cmp_b_wdata,
    input  logic               cmp_b_we,
    input  logic [1:0]         cmp_imm,
    input  logic [TABLE_W-1:0] act_a,
    input  logic [TABLE_W-1:0] act_b,
    output logic               pwm_a,
    output logic               pwm_b,
    output logic [CNT_W-1:0]   tb_count,
    output logic               evt_zero,
    output logic               evt_period
);

    localparam int unsigned NCH = 2;

    logic [CNT_W-1:0]   cnt;
    logic               dir_up;
    logic               at_zero;
    logic               at_top;
    logic [CNT_W-1:0]   wdata_arr [NCH];
    logic [NCH-1:0]     we_arr;
    logic [TABLE_W-1:0] tbl_arr   [NCH];
    logic [CNT_W-1:0]   cmp_arr   [NCH];
    logic [NCH-1:0]     pwm_arr;

    // Gather per-channel ports into arrays.
    always_comb begin
        wdata_arr[0] = cmp_a_wdata;
        wdata_arr[1] = cmp_b_wdata;
        we_arr       = {cmp_b_we, cmp_a_we};
        tbl_arr[0]   = act_a;
        tbl_arr[1]   = act_b;
    end

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period),
        .cnt     (cnt),
        .dir_up  (dir_up),
        .at_zero (at_zero),
        .at_top  (at_top)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (we_arr[ch]),
            .wdata    (wdata_arr[ch]),
            .imm      (cmp_imm[ch]),
            .load_evt (at_zero),
            .active   (cmp_arr[ch])
        );

        pwm_action_out #(.CNT_W(CNT_W)) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .cmp     (cmp_arr[ch]),
            .dir_up  (dir_up),
            .at_zero (at_zero),
            .at_top  (at_top),
            .table_i (tbl_arr[ch]),
            .pwm     (pwm_arr[ch])
        );
    end

    // Drive the outputs.
    always_comb begin
        pwm_a      = pwm_arr[0];
        pwm_b      = pwm_arr[1];
        tb_count   = cnt;
        evt_zero   = at_zero;
        evt_period = at_top;
    end

endmodule

// File: tb/test_pwm_center_gen.sv
module test_pwm_center_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period = 16'd100;
    logic [15:0] a_wd = '0, b_wd = '0;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [1:0]  imm = 2'b00;
    logic [7:0]  act_a = 8'h61, act_b = 8'h61;
    logic        pwm_a, pwm_b, evt_zero, evt_period;
    logic [15:0] tb_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_center_gen i_pwm_center_gen (
        .clk(clk), .rst_n(rst_n), .period(period),
        .cmp_a_wdata(a_wd), .cmp_a_we(a_we),
        .cmp_b_wdata(b_wd), .cmp_b_we(b_we),
        .cmp_imm(imm), .act_a(act_a), .act_b(act_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .tb_count(tb_count),
        .evt_zero(evt_zero), .evt_period(evt_period)
    );

    // Entries: {period, cmp A, cmp B, expected high A, expected high B}
    localparam logic [79:0] VEC [5] = '{
        {16'd100, 16'd50,  16'd25,  16'd100, 16'd150},
        {16'd100, 16'd0,   16'd100, 16'd0,   16'd0  },
        {16'd40,  16'd10,  16'd39,  16'd60,  16'd2  },
        {16'd100, 16'd120, 16'd1,   16'd0,   16'd198},
        {16'd7,   16'd3,   16'd6,   16'd8,   16'd2  }
    };

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One carrier cycle starting at a zero state; optional channel A writes at given offsets.
    task automatic run_window(input int w1_at, input logic [15:0] w1_val,
                              input int w2_at, input logic [15:0] w2_val,
                              output int ha, output int hb, output int nz,
                              output int np, output int cnt_top);
        int p;
        p = int'(period);
        ha = 0; hb = 0; nz = 0; np = 0; cnt_top = -1;
        while (tb_count != 16'd0) @(negedge clk);
        for (int i = 0; i < 2 * p; i++) begin
            if (i == w1_at) begin a_we = 1'b1; a_wd = w1_val; end
            else if (i == w2_at) begin a_we = 1'b1; a_wd = w2_val; end
            else a_we = 1'b0;
            ha += int'(pwm_a);
            hb += int'(pwm_b);
            nz += int'(evt_zero);
            np += int'(evt_period);
            if (i == p) cnt_top = int'(tb_count);
            @(negedge clk);
        end
        a_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ha, hb, nz, np, ct, hb1, hb2;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 count after reset", int'(tb_count), 0);
        check("R9 pwm_a after reset", int'(pwm_a), 0);
        check("R9 pwm_b after reset", int'(pwm_b), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first step up", int'(tb_count), 1);
        // R9: compares cleared -> no pulse with table 0x61
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        check("R9 A high with cleared compare", ha, 0);
        check("R9 B high with cleared compare", hb, 0);
        check("R2 zero events per cycle", nz, 1);
        check("R2 top events per cycle", np, 1);
        check("R1 count at half cycle", ct, 100);

        // R8 / R10 / R7: vector table
        foreach (VEC[k]) begin
            period = VEC[k][79:64];
            a_wd = VEC[k][63:48]; b_wd = VEC[k][47:32];
            a_we = 1'b1; b_we = 1'b1;
            @(negedge clk);
            a_we = 1'b0; b_we = 1'b0;
            run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
            run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
            run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
            check($sformatf("R8 R7 A vector %0d", k), ha, int'(VEC[k][31:16]));
            check($sformatf("R10 R8 B vector %0d", k), hb, int'(VEC[k][15:0]));
            check($sformatf("R1 top count vector %0d", k), ct, int'(VEC[k][79:64]));
        end

        // Directed: period 100, A=50, B=25 buffered
        period = 16'd100;
        a_wd = 16'd50; b_wd = 16'd25; a_we = 1'b1; b_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);

        // R3: write 72 mid-cycle keeps 50 for this cycle
        run_window(30, 16'd72, -1, 0, ha, hb, nz, np, ct);
        check("R3 running cycle keeps old width", ha, 100);
        check("R10 B untouched by A write", hb, 150);
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        check("R3 new width from next zero", ha, 56);

        // R4: two writes in one cycle, last wins
        run_window(10, 16'd30, 20, 16'd70, ha, hb, nz, np, ct);
        check("R4 cycle with two writes", ha, 56);
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        check("R4 last write applied", ha, 60);

        // R5: bypass mode changes running cycle
        imm = 2'b01;
        run_window(30, 16'd60, -1, 0, ha, hb, nz, np, ct);
        check("R5 bypass write takes effect at once", ha, 80);
        check("R10 B unaffected by A bypass", hb, 150);
        imm = 2'b00;

        // R6: high at top, low at zero on B
        act_b = 8'h09;
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        check("R6 set-at-top clear-at-zero", hb, 100);
        check("R10 A unaffected by B table", ha, 80);

        // R6: invert at zero alternates
        act_b = 8'h03;
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        run_window(-1, 0, -1, 0, ha, hb1, nz, np, ct);
        run_window(-1, 0, -1, 0, ha, hb2, nz, np, ct);
        check("R6 invert-at-zero two cycles", hb1 + hb2, 200);
        check("R6 invert-at-zero one cycle", (hb1 == 1 || hb1 == 199) ? 1 : 0, 1);
        act_b = 8'h61;

        // R9: reset while A is high
        while (tb_count != 16'd0) @(negedge clk);
        repeat (80) @(negedge clk);
        check("R8 A high mid pulse", int'(pwm_a), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 pwm_a cleared by reset", int'(pwm_a), 0);
        check("R9 count cleared by reset", int'(tb_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_window(-1, 0, -1, 0, ha, hb, nz, np, ct);
        check("R9 compare A cleared by reset", ha, 0);
        check("R9 compare B cleared by reset", hb, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule